// File: doc/BRIEF.md
# Floating-Point Context Frame Sequencer

This block moves the context frame of a floating-point unit between the unit and memory. On a save request it writes a fixed idle frame word by word through a request/acknowledge memory port. On a restore request it reads only the header word of a frame. It then works out from the header how many further words the frame body holds and steps the address past them. The frame contents themselves are never stored or loaded.

Two frame layouts are supported. The first is a seven-word legacy frame: a header, five zero words and a trailer. The second is a single-word compact frame. Three addressing styles are supported: plain indirect (ascending, no write-back), postincrement (ascending) and predecrement (descending, with the address lowered before each access). When the sequence ends the block reports the final address, and it flags whether that address should update the address register. It also raises a warning when a restored header carries a version it does not know.

Top module: `fp_frame_sequencer`

## Requirements
- R1: After reset, `mem_req`, `done`, `addr_wb` and `fmt_warn` are all 0.
- R2: A legacy save in plain (`am`=2'b00) or postincrement (`am`=2'b01) mode writes seven words at `start_addr`, +4, ..., +24. Their values are 0x1F180000, five words of 0, then 0x70000000. The final address is `start_addr`+28.
- R3: In predecrement mode (`am`=2'b10) every access is preceded by a decrement of 4. A save writes the address-highest word first, at `start_addr`-4, and goes down from there. A legacy save ends with the header at `start_addr`-28. The final address is the last accessed address.
- R4: A compact save (`compact`=1) writes the single word 0x41000000, at `start_addr` when ascending and at `start_addr`-4 when descending. The final address is `start_addr`+4 or `start_addr`-4.
- R5: Each memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is high.
- R6: A restore (`op_restore`=1) reads one header word, at `start_addr` when ascending and at `start_addr`-4 when descending. If header bits 31:24 are zero, the frame is null and no further skip is applied. The final address is then `start_addr`+4 or `start_addr`-4, with no warning.
- R7: A legacy restore skips further words according to header bits 23:16: 0x18 skips 6 words, 0x38 skips 14 and 0xB4 skips 45. The skip is added when ascending and subtracted when descending.
- R8: A compact restore skips further words according to header bits 23:16: 0x00 skips none, 0x30 skips 11 words (44 bytes) and 0x60 skips 23 words (92 bytes).
- R9: A non-null header whose version is not listed for the selected frame layout skips nothing further and raises `fmt_warn` together with `done`.
- R10: `addr_wb` is high with `done` only in postincrement or predecrement mode. It is 0 in plain mode and for `am`=2'b11, which behaves as plain.
- R11: `mem_req` rises the cycle after `start` is accepted. `done` is a one-cycle pulse that comes one cycle after the clock edge that takes the last acknowledge, and it comes with `end_addr` valid.
- R12: A `start` pulse while a sequence is in progress is ignored. The accesses and final address of the running sequence do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| op_restore | input | 1 | 0 = save frame, 1 = restore frame |
| am | input | 2 | Addressing: 00 plain, 01 postincrement, 10 predecrement, 11 plain |
| compact | input | 1 | 1 = one-word compact frame, 0 = seven-word legacy frame |
| start_addr | input | 32 | Byte address taken from the address register |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle end-of-sequence pulse |
| end_addr | output | 32 | Final address, valid from `done` |
| addr_wb | output | 1 | With `done`: final address should update the register |
| fmt_warn | output | 1 | With `done`: restored header version unknown |

## Verification
The first request is due one cycle after the edge that accepts `start`. The bench samples `mem_req` at the first falling edge after that edge. `done`, `end_addr`, `addr_wb` and `fmt_warn` are due one cycle after the edge that takes the final acknowledge. The bench notes the cycle in which its memory model raises the last acknowledge and requires `done` exactly one cycle later, then low again on the next cycle. Acknowledge latency is drawn at random from zero to three cycles, so holding a request and stepping between words are both exercised under varying wait times. All checks sample on the falling clock edge.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

   typedef enum logic [1:0] {
      AM_PLAIN   = 2'b00,
      AM_POSTINC = 2'b01,
      AM_PREDEC  = 2'b10,
      AM_RSVD    = 2'b11
   } addr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_WRITE = 2'b01,
      ST_READ  = 2'b10
   } seq_state_e;

   // width of a word count applied to the address stepper
   localparam int SKIP_W = 6;

   // fixed frame words
   localparam logic [7:0]  LEG_HDR_TOP  = 8'h1F;
   localparam logic [31:0] LEG_TRAILER  = 32'h7000_0000;
   localparam logic [31:0] CPT_WORD     = 32'h4100_0000;

   // restore versions and their body lengths in words
   localparam logic [7:0] LEG_V_A = 8'h18;
   localparam logic [7:0] LEG_V_B = 8'h38;
   localparam logic [7:0] LEG_V_C = 8'hB4;
   localparam int         LEG_S_A = 6;
   localparam int         LEG_S_B = 14;
   localparam int         LEG_S_C = 45;

   localparam logic [7:0] CPT_V_A = 8'h00;
   localparam logic [7:0] CPT_V_B = 8'h30;
   localparam logic [7:0] CPT_V_C = 8'h60;
   localparam int         CPT_S_A = 0;
   localparam int         CPT_S_B = 11;
   localparam int         CPT_S_C = 23;

endpackage

// File: rtl/frame_word_gen.sv
module frame_word_gen #(
   parameter int         DATA_W    = 32,
   parameter int         LEG_WORDS = 7,
   parameter int         IDX_W     = 3,
   parameter logic [7:0] VERSION   = 8'h18
) (
   input  logic              compact,
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   import frame_seq_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEG_WORDS - 1);
   localparam logic [31:0]      LEG_HDR  = {LEG_HDR_TOP, VERSION, 16'h0000};

   // idx counts in ascending address order within the frame
   always_comb begin
      word = '0;
      if (compact) begin
         if (idx == '0) word = CPT_WORD;
      end else if (idx == '0) begin
         word = LEG_HDR;
      end else if (idx == LAST_IDX) begin
         word = LEG_TRAILER;
      end
   end

endmodule

// File: rtl/frame_skip_decode.sv
module frame_skip_decode #(
   parameter int DATA_W      = 32,
   parameter bit HAS_COMPACT = 1'b1
) (
   input  logic                              compact,
   input  logic [DATA_W-1:0]                 hdr,
   output logic [frame_seq_pkg::SKIP_W-1:0]  skip,
   output logic                              warn
);
   import frame_seq_pkg::*;

   logic             is_null;
   logic [7:0]       ver;
   logic [SKIP_W-1:0] leg_skip, cpt_skip;
   logic             leg_bad, cpt_bad;

   assign is_null = (hdr[31:24] == 8'h00);
   assign ver     = hdr[23:16];

   always_comb begin
      leg_bad  = 1'b0;
      leg_skip = '0;
      unique case (ver)
         LEG_V_A: leg_skip = SKIP_W'(LEG_S_A);
         LEG_V_B: leg_skip = SKIP_W'(LEG_S_B);
         LEG_V_C: leg_skip = SKIP_W'(LEG_S_C);
         default: leg_bad  = 1'b1;
      endcase
   end

   generate
      if (HAS_COMPACT) begin : g_cpt
         always_comb begin
            cpt_bad  = 1'b0;
            cpt_skip = '0;
            unique case (ver)
               CPT_V_A: cpt_skip = SKIP_W'(CPT_S_A);
               CPT_V_B: cpt_skip = SKIP_W'(CPT_S_B);
               CPT_V_C: cpt_skip = SKIP_W'(CPT_S_C);
               default: cpt_bad  = 1'b1;
            endcase
         end
      end else begin : g_no_cpt
         assign cpt_bad  = leg_bad;
         assign cpt_skip = leg_skip;
      end
   endgenerate

   always_comb begin
      if (is_null) begin
         skip = '0;
         warn = 1'b0;
      end else if (compact) begin
         skip = cpt_skip;
         warn = cpt_bad;
      end else begin
         skip = leg_skip;
         warn = leg_bad;
      end
   end

endmodule

// File: rtl/frame_addr_step.sv
module frame_addr_step #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              down,
   input  logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] addr_out
);
   logic [ADDR_W-1:0] delta;

   always_comb begin
      delta = '0;
      delta[CNT_W+1:0] = {count, 2'b00};
      addr_out = down ? (base - delta) : (base + delta);
   end

endmodule

// File: rtl/fp_frame_sequencer.sv
module fp_frame_sequencer #(
   parameter int         ADDR_W      = 32,
   parameter int         DATA_W      = 32,
   parameter int         LEG_WORDS   = 7,
   parameter logic [7:0] VERSION     = 8'h18,
   parameter bit         HAS_COMPACT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_restore,
   input  logic [1:0]        am,
   input  logic              compact,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] end_addr,
   output logic              addr_wb,
   output logic              fmt_warn
);
   import frame_seq_pkg::*;

   localparam int IDX_W = $clog2(LEG_WORDS);
   localparam logic [IDX_W-1:0] LEG_LAST = IDX_W'(LEG_WORDS - 1);
   localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("fp_frame_sequencer: DATA_W must be 32");
      end
      if (ADDR_W < 8) begin : g_chk_addr
         $error("fp_frame_sequencer: ADDR_W too small");
      end
      if (LEG_WORDS < 2 || LEG_WORDS > 16) begin : g_chk_words
         $error("fp_frame_sequencer: LEG_WORDS out of range");
      end
   endgenerate

   seq_state_e        state;
   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W-1:0]  cnt;
   logic              down_q, wb_q, comp_q;
   logic              done_q, wbo_q, warn_q;
   logic [ADDR_W-1:0] end_q;

   addr_mode_e        mode_in;
   logic              comp_in;
   logic              last;
   logic [IDX_W-1:0]  last_idx, widx;
   logic [SKIP_W-1:0] skip, step_cnt;
   logic              dec_warn;
   logic [ADDR_W-1:0] step_addr;
   logic [DATA_W-1:0] frame_word;

   assign mode_in = addr_mode_e'(am);

   generate
      if (HAS_COMPACT) begin : g_cpt_sel
         assign comp_in = compact;
      end else begin : g_leg_only
         assign comp_in = 1'b0;
      end
   endgenerate

   assign last_idx = comp_q ? '0 : LEG_LAST;
   assign last     = (cnt == last_idx);
   // descending saves emit the frame from its highest word downward
   assign widx     = down_q ? (last_idx - cnt) : cnt;

   frame_word_gen #(
      .DATA_W    (DATA_W),
      .LEG_WORDS (LEG_WORDS),
      .IDX_W     (IDX_W),
      .VERSION   (VERSION)
   ) u_word (
      .compact (comp_q),
      .idx     (widx),
      .word    (frame_word)
   );

   frame_skip_decode #(
      .DATA_W      (DATA_W),
      .HAS_COMPACT (HAS_COMPACT)
   ) u_skip (
      .compact (comp_q),
      .hdr     (mem_rdata),
      .skip    (skip),
      .warn    (dec_warn)
   );

   // one stepper serves both word advance and final address
   always_comb begin
      if (state == ST_READ) begin
         step_cnt = down_q ? skip : skip + SKIP_W'(1);
      end else begin
         step_cnt = (last && down_q) ? '0 : SKIP_W'(1);
      end
   end

   frame_addr_step #(
      .ADDR_W (ADDR_W),
      .CNT_W  (SKIP_W)
   ) u_step (
      .base     (cur_addr),
      .down     (down_q),
      .count    (step_cnt),
      .addr_out (step_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_addr <= '0;
         cnt      <= '0;
         down_q   <= 1'b0;
         wb_q     <= 1'b0;
         comp_q   <= 1'b0;
         done_q   <= 1'b0;
         wbo_q    <= 1'b0;
         warn_q   <= 1'b0;
         end_q    <= '0;
      end else begin
         done_q <= 1'b0;
         wbo_q  <= 1'b0;
         warn_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  down_q   <= (mode_in == AM_PREDEC);
                  wb_q     <= (mode_in == AM_PREDEC) || (mode_in == AM_POSTINC);
                  comp_q   <= comp_in;
                  cnt      <= '0;
                  cur_addr <= (mode_in == AM_PREDEC) ? start_addr - WORD_BYTES
                                                     : start_addr;
                  state    <= op_restore ? ST_READ : ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  if (last) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     wbo_q  <= wb_q;
                     end_q  <= step_addr;
                  end else begin
                     cur_addr <= step_addr;
                     cnt      <= cnt + IDX_W'(1);
                  end
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  wbo_q  <= wb_q;
                  warn_q <= dec_warn;
                  end_q  <= step_addr;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == ST_WRITE) || (state == ST_READ);
   assign mem_we    = (state == ST_WRITE);
   assign mem_addr  = cur_addr;
   assign mem_wdata = mem_we ? frame_word : '0;
   assign done      = done_q;
   assign end_addr  = end_q;
   assign addr_wb   = wbo_q;
   assign fmt_warn  = warn_q;

   // R5: an outstanding request keeps its contents until acknowledged
   a_r5_hold_req : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                 && $stable(mem_we) && $stable(mem_wdata)));

   // R11: an accepted start raises a request on the next cycle
   a_r11_req_follows_start : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> mem_req);

   // R11: done is a single-cycle pulse with no request alongside
   a_r11_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   // R9 / R10: the qualifier outputs appear only with done
   a_r9_warn_with_done : assert property (@(posedge clk) disable iff (!rst_n)
      fmt_warn |-> done);
   a_r10_wb_with_done : assert property (@(posedge clk) disable iff (!rst_n)
      addr_wb |-> done);

   // R3: consecutive descending writes step the address down by one word
   a_r3_desc_step : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && down_q && !last)
         |=> (mem_addr == $past(mem_addr) - WORD_BYTES));

endmodule

// File: tb/test_fp_frame_sequencer.sv
module test_fp_frame_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_restore = 1'b0;
   logic [1:0]  am = 2'b00;
   logic        compact = 1'b0;
   logic [31:0] start_addr = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, addr_wb, fmt_warn;
   logic [31:0] end_addr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int last_ack_cyc = 0;
   int wait_n = 0;
   logic [31:0] rd_val = '0;
   int cap_n = 0;
   logic [31:0] cap_a [0:15];
   logic [31:0] cap_d [0:15];
   logic        cap_w [0:15];

   always #2.5 clk = ~clk;

   fp_frame_sequencer i_fp_frame_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_restore (op_restore),
      .am         (am),
      .compact    (compact),
      .start_addr (start_addr),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .done       (done),
      .end_addr   (end_addr),
      .addr_wb    (addr_wb),
      .fmt_warn   (fmt_warn)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // memory model: random 0..3 cycle acknowledge latency
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wait_n  = int'($urandom % 4);
      end else if (mem_req) begin
         if (wait_n == 0) begin
            if (cap_n < 16) begin
               cap_a[cap_n] = mem_addr;
               cap_d[cap_n] = mem_wdata;
               cap_w[cap_n] = mem_we;
            end
            cap_n        = cap_n + 1;
            mem_rdata    = rd_val;
            mem_ack      = 1'b1;
            last_ack_cyc = cyc;
         end else begin
            wait_n = wait_n - 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] frame_word(input int k, input bit comp);
      if (comp) return (k == 0) ? 32'h4100_0000 : 32'h0;
      if (k == 0) return 32'h1F18_0000;
      if (k == 6) return 32'h7000_0000;
      return 32'h0;
   endfunction

   function automatic int exp_skip(input bit comp, input logic [31:0] h,
                                   output bit warn);
      warn = 1'b0;
      if (h[31:24] == 8'h00) return 0;
      if (comp) begin
         case (h[23:16])
            8'h00: return 0;
            8'h30: return 11;
            8'h60: return 23;
            default: begin warn = 1'b1; return 0; end
         endcase
      end
      case (h[23:16])
         8'h18: return 6;
         8'h38: return 14;
         8'hB4: return 45;
         default: begin warn = 1'b1; return 0; end
      endcase
   endfunction

   task automatic run_op(input bit op, input logic [1:0] mode, input bit comp,
                         input logic [31:0] a, input logic [31:0] hdr,
                         input bit inject, input string tag);
      logic [31:0] ea [0:7];
      logic [31:0] ed [0:7];
      logic [31:0] fin;
      bit   down, ewb, ewarn, seq_ok;
      int   n, sk, it;
      down  = (mode == 2'b10);
      ewb   = (mode == 2'b01) || (mode == 2'b10);
      ewarn = 1'b0;
      if (!op) begin
         n = comp ? 1 : 7;
         for (int k = 0; k < n; k++) begin
            if (down) begin
               ea[k] = a - 32'(4 * (k + 1));
               ed[k] = frame_word(n - 1 - k, comp);
            end else begin
               ea[k] = a + 32'(4 * k);
               ed[k] = frame_word(k, comp);
            end
         end
         fin = down ? a - 32'(4 * n) : a + 32'(4 * n);
      end else begin
         n     = 1;
         ea[0] = down ? a - 32'd4 : a;
         ed[0] = 32'h0;
         sk    = exp_skip(comp, hdr, ewarn);
         fin   = down ? a - 32'(4 + 4 * sk) : a + 32'(4 + 4 * sk);
      end

      @(negedge clk);
      cap_n      = 0;
      rd_val     = hdr;
      op_restore = op;
      am         = mode;
      compact    = comp;
      start_addr = a;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(mem_req === 1'b1, {"R11 req after start ", tag}, 32'(mem_req), 32'd1);
      it = 0;
      while (done !== 1'b1 && it < 400) begin
         @(negedge clk);
         it++;
         if (inject && it == 1) begin
            start      = 1'b1;
            start_addr = a ^ 32'h0000_1000;
            op_restore = ~op;
            am         = 2'b01;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      check(done === 1'b1, {"R11 done seen ", tag}, 32'(done), 32'd1);
      check(cyc == last_ack_cyc + 1, {"R11 done timing ", tag},
            32'(cyc), 32'(last_ack_cyc + 1));
      check(mem_req === 1'b0, {"R11 idle at done ", tag}, 32'(mem_req), 32'd0);
      seq_ok = (cap_n == n);
      for (int k = 0; k < n && k < 16; k++) begin
         if (cap_a[k] !== ea[k] || cap_w[k] !== !op) seq_ok = 1'b0;
         if (!op && cap_d[k] !== ed[k]) seq_ok = 1'b0;
      end
      if (op)
         check(seq_ok, {"R6 header read ", tag}, cap_a[0], ea[0]);
      else if (down)
         check(seq_ok, {"R3 descending save ", tag}, cap_a[0], ea[0]);
      else if (comp)
         check(seq_ok, {"R4 compact save ", tag}, cap_d[0], ed[0]);
      else
         check(seq_ok, {"R2 legacy save ", tag}, 32'(cap_n), 32'(n));
      if (inject)
         check(seq_ok && end_addr === fin, {"R12 start ignored ", tag}, end_addr, fin);
      if (op)
         check(end_addr === fin, {"R7 R8 final address ", tag}, end_addr, fin);
      else
         check(end_addr === fin, {"R2 R3 R4 final address ", tag}, end_addr, fin);
      check(fmt_warn === ewarn, {"R9 warning ", tag}, 32'(fmt_warn), 32'(ewarn));
      check(addr_wb === ewb, {"R10 write-back ", tag}, 32'(addr_wb), 32'(ewb));
      @(negedge clk);
      check(done === 1'b0, {"R11 done pulse width ", tag}, 32'(done), 32'd0);
   endtask

   initial begin
      int seed;
      seed = int'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(mem_req === 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
      check(done === 1'b0, "R1 done", 32'(done), 32'd0);
      check(addr_wb === 1'b0, "R1 addr_wb", 32'(addr_wb), 32'd0);
      check(fmt_warn === 1'b0, "R1 fmt_warn", 32'(fmt_warn), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // saves: R2, R3, R4, R10
      run_op(1'b0, 2'b01, 1'b0, 32'h0000_1000, 32'h0, 1'b0, "postinc legacy");
      run_op(1'b0, 2'b00, 1'b0, 32'h0000_2000, 32'h0, 1'b0, "plain legacy");
      run_op(1'b0, 2'b10, 1'b0, 32'h0000_3000, 32'h0, 1'b0, "predec legacy");
      run_op(1'b0, 2'b01, 1'b1, 32'h0000_4000, 32'h0, 1'b0, "postinc compact");
      run_op(1'b0, 2'b10, 1'b1, 32'h0000_5000, 32'h0, 1'b0, "predec compact");
      run_op(1'b0, 2'b11, 1'b1, 32'h0000_6000, 32'h0, 1'b0, "mode3 compact");
      run_op(1'b0, 2'b10, 1'b0, 32'h0000_0000, 32'h0, 1'b0, "predec wrap");

      // restores: R6 null, R7 legacy, R8 compact, R9 unknown
      run_op(1'b1, 2'b01, 1'b0, 32'h0000_7000, 32'h0018_0000, 1'b0, "null up");
      run_op(1'b1, 2'b10, 1'b1, 32'h0000_7100, 32'h0060_0000, 1'b0, "null down");
      run_op(1'b1, 2'b01, 1'b0, 32'h0000_8000, 32'h1F18_0000, 1'b0, "leg 18 up");
      run_op(1'b1, 2'b10, 1'b0, 32'h0000_8100, 32'h1F38_0000, 1'b0, "leg 38 down");
      run_op(1'b1, 2'b01, 1'b0, 32'h0000_8200, 32'h1FB4_0000, 1'b0, "leg B4 up");
      run_op(1'b1, 2'b10, 1'b0, 32'h0000_8300, 32'h1FB4_0000, 1'b0, "leg B4 down");
      run_op(1'b1, 2'b01, 1'b1, 32'h0000_9000, 32'h4100_0000, 1'b0, "cpt 00 up");
      run_op(1'b1, 2'b10, 1'b1, 32'h0000_9100, 32'h4130_0000, 1'b0, "cpt 30 down");
      run_op(1'b1, 2'b00, 1'b1, 32'h0000_9200, 32'h4160_0000, 1'b0, "cpt 60 plain");
      run_op(1'b1, 2'b01, 1'b0, 32'h0000_A000, 32'h1F30_0000, 1'b0, "leg unknown");
      run_op(1'b1, 2'b10, 1'b1, 32'h0000_A100, 32'h4118_0000, 1'b0, "cpt unknown");

      // R12 start while busy
      run_op(1'b0, 2'b01, 1'b0, 32'h0000_B000, 32'h0, 1'b1, "inject save");
      run_op(1'b1, 2'b10, 1'b0, 32'h0000_B100, 32'h1F38_0000, 1'b1, "inject restore");

      // constrained random mix
      for (int r = 0; r < 40; r++) begin
         logic [31:0] h;
         logic [7:0]  vpick;
         int          sel;
         sel = int'($urandom % 7);
         case (sel)
            0: vpick = 8'h00;
            1: vpick = 8'h18;
            2: vpick = 8'h30;
            3: vpick = 8'h38;
            4: vpick = 8'h60;
            5: vpick = 8'hB4;
            default: vpick = 8'($urandom);
         endcase
         h = {(($urandom % 5) == 0) ? 8'h00 : 8'h41, vpick, 16'($urandom)};
         run_op(1'($urandom), 2'($urandom), 1'($urandom),
                {$urandom} & 32'hFFFF_FFFC, h, (($urandom % 6) == 0), "random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule